// File: doc/BRIEF.md
# Configuration Write-Lock Guard

This block stands between a synchronous host register bus and three groups of configuration registers: chip control, network identity and PHY control. Each group has its own lock. A lock opens only when a fixed key byte is written to that group's lock register. While a group is locked, host writes to its registers are dropped without any error.

The block holds the two chip control registers itself. One is a write-only command register with a soft-reset bit. The other holds a global interrupt enable and a clock select. The network and PHY registers live outside the block, and they see only the gated write strobes that come out of here. A read-only status byte shows the live state of each lock and which host interface strap is selected.

Top module: `cfg_lock_guard`

## Requirements
- R1: After reset all three groups are locked, the status byte reads 0xE0 plus the interface bits, and the chip config byte 1 reads 0x80.
- R2: The lock registers sit at LOCK_BASE+0 (chip), LOCK_BASE+1 (network) and LOCK_BASE+2 (PHY). Writing 0xCE to one of them unlocks that group, and the new state shows in status from the next cycle.
- R3: Writing any value other than 0xCE to a lock register locks that group. The other groups are not affected.
- R4: The status byte holds the chip lock in bit 7, the network lock in bit 6 and the PHY lock in bit 5, where 1 means locked. Bits 4 to 2 read 0. Bit 1 is 1 when the parallel interface is selected (host_spi=0), and bit 0 is 1 when SPI is selected (host_spi=1).
- R5: net_we is high in the same cycle as a bus write whose address falls in [NET_BASE, NET_BASE+NET_SPAN), but only while the network group is unlocked. It is never high without a bus write.
- R6: phy_we[i] is high in the same cycle as a bus write to PHY_BASE+i, but only while the PHY group is unlocked. At most one bit is high at a time.
- R7: While the chip group is unlocked, a write to chip config byte 1 updates bit 7 (irq_en) and bit 0 (clk_sel), and its other bits read 0. While the chip group is locked, such a write leaves the byte unchanged.
- R8: While the chip group is unlocked, writing chip config byte 0 with bit 7 set raises soft_rst for exactly the one following cycle. While the chip group is locked, no pulse is produced.
- R9: Chip config byte 0 reads 0x80 in the first cycle after reset and in the cycle of a soft-reset pulse. At all other times it reads 0x00.
- R10: The lock registers are write-only and always read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_spi | input | 1 | Host interface strap: 1 selects SPI, 0 selects the parallel bus |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| net_we | output | 1 | Gated write enable for the network register window |
| phy_we | output | PHY_N | Gated write enables for the PHY control registers |
| soft_rst | output | 1 | One-cycle soft reset pulse |
| irq_en | output | 1 | Global interrupt enable |
| clk_sel | output | 1 | System clock select |

## Verification
A lock bit stuck in the wrong state shows in the status byte on the next read. It also shows in the same cycle as a write strobe, because net_we or phy_we appears or stays low at that moment. A wrong key compare shows one cycle after the lock write, in the status byte. A soft-reset flag that is wrong shows as a missing, doubled or spurious soft_rst pulse. It also shows as a config byte 0 readback other than 0x80 exactly in the pulse cycle. Config byte 1 corruption shows directly on irq_en and clk_sel.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
    localparam logic [7:0] UNLOCK_KEY = 8'hCE;
    localparam int NUM_GRP = 3;
    typedef enum logic [1:0] {GRP_CHIP = 2'd0, GRP_NET = 2'd1, GRP_PHY = 2'd2} grp_e;
endpackage

// File: rtl/lock_bank.sv
module lock_bank
    import cfg_lock_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_GRP-1:0] lock_wr,
    input  logic [7:0]         wdata,
    output logic [NUM_GRP-1:0] locked
);
    typedef struct packed {
        logic [NUM_GRP-1:0] lk;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (lock_wr[g]) st_d.lk[g] = (wdata != UNLOCK_KEY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lk: '1};
        else        st_q <= st_d;
    end

    assign locked = st_q.lk;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
        // R2
        key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_wr[g] && wdata == UNLOCK_KEY) |=> !locked[g]);
        // R3
        other_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_wr[g] && wdata != UNLOCK_KEY) |=> locked[g]);
    end
endmodule

// File: rtl/addr_decode.sv
module addr_decode #(
    parameter int ADDR_W    = 8,
    parameter int STAT_ADDR = 'h00,
    parameter int CFG0_ADDR = 'h04,
    parameter int CFG1_ADDR = 'h05,
    parameter int PHY_BASE  = 'h10,
    parameter int PHY_N     = 2,
    parameter int NET_BASE  = 'h20,
    parameter int NET_SPAN  = 'h20,
    parameter int LOCK_BASE = 'hF0,
    parameter int NUM_GRP   = 3
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic               sel_stat,
    output logic               sel_cfg0,
    output logic               sel_cfg1,
    output logic               sel_net,
    output logic [PHY_N-1:0]   sel_phy,
    output logic [NUM_GRP-1:0] sel_lock
);
    localparam int NET_END = NET_BASE + NET_SPAN;
    int a;

    always_comb begin
        a        = int'(addr);
        sel_stat = (a == STAT_ADDR);
        sel_cfg0 = (a == CFG0_ADDR);
        sel_cfg1 = (a == CFG1_ADDR);
        sel_net  = (a >= NET_BASE) && (a < NET_END);
    end

    for (genvar i = 0; i < PHY_N; i++) begin : g_phy
        assign sel_phy[i] = (int'(addr) == PHY_BASE + i);
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_lock
        assign sel_lock[g] = (int'(addr) == LOCK_BASE + g);
    end
endmodule

// File: rtl/sys_cfg_regs.sv
module sys_cfg_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_cfg0,
    input  logic       wr_cfg1,
    input  logic [7:0] wdata,
    output logic [7:0] cfg0_rd,
    output logic [7:0] cfg1_rd,
    output logic       soft_rst
);
    typedef struct packed {
        logic rst_flag;
        logic pulse;
        logic ien;
        logic csel;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.rst_flag = wr_cfg0 && wdata[7];
        st_d.pulse    = wr_cfg0 && wdata[7];
        if (wr_cfg1) begin
            st_d.ien  = wdata[7];
            st_d.csel = wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{rst_flag: 1'b1, pulse: 1'b0, ien: 1'b1, csel: 1'b0};
        else        st_q <= st_d;
    end

    assign cfg0_rd  = {st_q.rst_flag, 7'b0};
    assign cfg1_rd  = {st_q.ien, 6'b0, st_q.csel};
    assign soft_rst = st_q.pulse;

    // R8
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg0 && wdata[7]) |=> soft_rst);
    // R7
    cfg1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cfg1 |=> $stable(cfg1_rd));
endmodule

// File: rtl/cfg_lock_guard.sv
module cfg_lock_guard
    import cfg_lock_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int STAT_ADDR = 'h00,
    parameter int CFG0_ADDR = 'h04,
    parameter int CFG1_ADDR = 'h05,
    parameter int PHY_BASE  = 'h10,
    parameter int PHY_N     = 2,
    parameter int NET_BASE  = 'h20,
    parameter int NET_SPAN  = 'h20,
    parameter int LOCK_BASE = 'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_spi,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              net_we,
    output logic [PHY_N-1:0]  phy_we,
    output logic              soft_rst,
    output logic              irq_en,
    output logic              clk_sel
);
    logic               sel_stat, sel_cfg0, sel_cfg1, sel_net;
    logic [PHY_N-1:0]   sel_phy;
    logic [NUM_GRP-1:0] sel_lock, locked;
    logic [7:0]         cfg0_rd, cfg1_rd, status;
    logic               chip_open;

    addr_decode #(
        .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CFG0_ADDR(CFG0_ADDR),
        .CFG1_ADDR(CFG1_ADDR), .PHY_BASE(PHY_BASE), .PHY_N(PHY_N),
        .NET_BASE(NET_BASE), .NET_SPAN(NET_SPAN), .LOCK_BASE(LOCK_BASE),
        .NUM_GRP(NUM_GRP)
    ) u_dec (
        .addr(bus_addr), .sel_stat(sel_stat), .sel_cfg0(sel_cfg0),
        .sel_cfg1(sel_cfg1), .sel_net(sel_net), .sel_phy(sel_phy),
        .sel_lock(sel_lock)
    );

    lock_bank u_locks (
        .clk(clk), .rst_n(rst_n),
        .lock_wr(sel_lock & {NUM_GRP{bus_wr}}),
        .wdata(bus_wdata), .locked(locked)
    );

    assign chip_open = !locked[GRP_CHIP];

    sys_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_cfg0(bus_wr && sel_cfg0 && chip_open),
        .wr_cfg1(bus_wr && sel_cfg1 && chip_open),
        .wdata(bus_wdata), .cfg0_rd(cfg0_rd), .cfg1_rd(cfg1_rd),
        .soft_rst(soft_rst)
    );

    assign net_we  = bus_wr && sel_net && !locked[GRP_NET];
    assign phy_we  = sel_phy & {PHY_N{bus_wr && !locked[GRP_PHY]}};
    assign irq_en  = cfg1_rd[7];
    assign clk_sel = cfg1_rd[0];
    assign status  = {locked[GRP_CHIP], locked[GRP_NET], locked[GRP_PHY],
                      3'b000, !host_spi, host_spi};

    always_comb begin
        bus_rdata = 8'h00;
        if (sel_stat)      bus_rdata = status;
        else if (sel_cfg0) bus_rdata = cfg0_rd;
        else if (sel_cfg1) bus_rdata = cfg1_rd;
    end

    // R5
    net_we_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |-> !net_we);
    // R6
    phy_we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phy_we));
    // R8
    soft_rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !bus_wr) |=> !soft_rst);
endmodule

// File: tb/cfg_lock_guard_bench.sv
module cfg_lock_guard_bench;
    localparam logic [7:0] A_STAT = 8'h00, A_CFG0 = 8'h04, A_CFG1 = 8'h05;
    localparam logic [7:0] A_PHY = 8'h10, A_NET = 8'h20, A_LOCK = 8'hF0;
    localparam logic [7:0] KEY = 8'hCE;

    logic       clk = 0, rst_n = 0, host_spi = 1, bus_wr = 0;
    logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
    logic       net_we, soft_rst, irq_en, clk_sel;
    logic [1:0] phy_we;
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    cfg_lock_guard u_cfg_lock_guard (
        .clk(clk), .rst_n(rst_n), .host_spi(host_spi), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .net_we(net_we), .phy_we(phy_we), .soft_rst(soft_rst),
        .irq_en(irq_en), .clk_sel(clk_sel)
    );

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk); bus_wr = 0; bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_addr = A_CFG0;
        repeat (3) @(negedge clk);
        rst_n = 1; #1;
        chk("R9 cfg0 right after reset", bus_rdata, 8'h80);
        rd(A_CFG0, v); chk("R9 cfg0 settles", v, 8'h00);
        rd(A_STAT, v); chk("R1 status at reset", v, 8'hE1);
        rd(A_CFG1, v); chk("R1 cfg1 at reset", v, 8'h80);
    endtask

    task automatic t_status_if();
        logic [7:0] v;
        host_spi = 0;
        rd(A_STAT, v); chk("R4 parallel strap", v, 8'hE2);
        host_spi = 1;
        rd(A_STAT, v); chk("R4 spi strap", v, 8'hE1);
    endtask

    task automatic t_locked_writes();
        logic [7:0] v;
        @(negedge clk); bus_wr = 1; bus_addr = A_NET + 8'h05; bus_wdata = 8'h11; #1;
        chk("R5 net_we while locked", {7'b0, net_we}, 8'h00);
        bus_addr = A_PHY + 8'h01; #1;
        chk("R6 phy_we while locked", {6'b0, phy_we}, 8'h00);
        @(negedge clk); bus_wr = 0;
        wr(A_CFG1, 8'h01);
        rd(A_CFG1, v); chk("R7 cfg1 locked write dropped", v, 8'h80);
        wr(A_CFG0, 8'h80); #1;
        chk("R8 no pulse while locked", {7'b0, soft_rst}, 8'h00);
    endtask

    task automatic t_unlock_each();
        logic [7:0] v;
        wr(A_LOCK + 8'd1, KEY);
        rd(A_STAT, v); chk("R2 net unlock", v, 8'hA1);
        wr(A_LOCK + 8'd2, KEY);
        rd(A_STAT, v); chk("R2 phy unlock", v, 8'h81);
        wr(A_LOCK, KEY);
        rd(A_STAT, v); chk("R2 chip unlock", v, 8'h01);
        for (int i = 0; i < 3; i++) begin
            rd(A_LOCK + 8'(i), v); chk("R10 lock reg reads zero", v, 8'h00);
        end
    endtask

    task automatic t_open_writes();
        logic [7:0] v;
        @(negedge clk); bus_wr = 1; bus_addr = A_NET; bus_wdata = 8'h33; #1;
        chk("R5 net_we low edge", {7'b0, net_we}, 8'h01);
        bus_addr = A_NET + 8'h1F; #1;
        chk("R5 net_we high edge", {7'b0, net_we}, 8'h01);
        bus_addr = A_NET + 8'h20; #1;
        chk("R5 net_we past window", {7'b0, net_we}, 8'h00);
        bus_addr = A_PHY; #1;
        chk("R6 phy_we[0]", {6'b0, phy_we}, 8'h01);
        bus_addr = A_PHY + 8'h01; #1;
        chk("R6 phy_we[1]", {6'b0, phy_we}, 8'h02);
        @(negedge clk); bus_wr = 0; #1;
        chk("R5 no strobe without write", {6'b0, phy_we, net_we}, 8'h00);
        wr(A_CFG1, 8'h7F);
        rd(A_CFG1, v); chk("R7 cfg1 write", v, 8'h01);
        chk("R7 irq_en/clk_sel", {6'b0, irq_en, clk_sel}, 8'h01);
    endtask

    task automatic t_soft_reset();
        @(negedge clk); bus_wr = 1; bus_addr = A_CFG0; bus_wdata = 8'h80;
        @(negedge clk); bus_wr = 0; #1;
        chk("R8 pulse high", {7'b0, soft_rst}, 8'h01);
        chk("R9 cfg0 during pulse", bus_rdata, 8'h80);
        @(negedge clk); #1;
        chk("R8 pulse one cycle", {7'b0, soft_rst}, 8'h00);
        chk("R9 cfg0 after pulse", bus_rdata, 8'h00);
        wr(A_CFG0, 8'h7F); #1;
        chk("R8 no pulse bit7 clear", {7'b0, soft_rst}, 8'h00);
    endtask

    task automatic t_relock();
        logic [7:0] v;
        wr(A_LOCK + 8'd1, 8'hCF);
        rd(A_STAT, v); chk("R3 net relock", v, 8'h41);
        wr(A_LOCK, 8'h00);
        rd(A_STAT, v); chk("R3 chip relock", v, 8'hC1);
        wr(A_CFG1, 8'h80);
        rd(A_CFG1, v); chk("R7 cfg1 held after relock", v, 8'h01);
        @(negedge clk); bus_wr = 1; bus_addr = A_PHY; bus_wdata = 8'h00; #1;
        chk("R3 phy still open", {6'b0, phy_we}, 8'h01);
        @(negedge clk); bus_wr = 0;
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_status_if();
        t_locked_writes();
        t_unlock_each();
        t_open_writes();
        t_soft_reset();
        t_relock();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule